// File: doc/BRIEF.md
# H5 Inverter Gate Pattern Generator

This block turns a signed sine reference sample into the five gate commands of a single-phase H5 bridge. The H5 bridge is a full bridge with an extra switch in the DC link. The reference sign chooses the half-cycle. In each half-cycle one upper switch stays on. The DC-link switch S5 and the opposite lower switch are pulsed whenever the reference magnitude is above an internal triangular carrier. This gives unipolar PWM. When S5 opens, the bridge freewheels through the held switch and a body diode. This separates the panel from the grid, so the common-mode voltage stays at half the link voltage.

The carrier is an up/down counter with a parameter-set peak, so it produces one valley every 2·PEAK clocks. A new half-cycle sign is taken only at a valley. Every turn-on is delayed by a dead time of DEAD clocks after the most recent turn-off. When the block is disabled or held in reset, all gates are low.

Top module: `h5_gate_gen`

## Requirements
- R1: While rst_n is low, all five gates are low and mode_o is 0. In any cycle that follows a clock edge where en was low, all five gates are low and mode_o is 0.
- R2: The carrier rises by one per clock from 0 up to PEAK, then falls by one per clock back to 0, so one full period is 2·PEAK clocks. It starts at 0 and rising when reset is released, and it keeps running while en is low.
- R3: Gate bits are gate_o[0]=S1, [1]=S2, [2]=S3, [3]=S4, [4]=S5. In the positive half, when |ref_in| is greater than the carrier, the target pattern is 5'b11001 (S5, S4, S1) and mode_o is 0.
- R4: In the positive half, when |ref_in| is not greater than the carrier, the target pattern is 5'b00001 (S1 alone) and mode_o is 1.
- R5: In the negative half, when |ref_in| is greater than the carrier, the target pattern is 5'b10110 (S5, S3, S2) and mode_o is 2.
- R6: In the negative half, when |ref_in| is not greater than the carrier, the target pattern is 5'b00100 (S3 alone) and mode_o is 3.
- R7: The half-cycle is a register that resets to positive. It loads the sign of ref_in (negative when below zero) only on a clock edge where the carrier is 0. If the sign of ref_in disagrees with the registered half, the freewheeling pattern of the registered half is the target.
- R8: A gate that is on and not in the target pattern turns off at the next edge. A gate that is off and in the target pattern turns on only when no gate turns off on that edge and at least DEAD clocks have passed since the last turn-off, since enable rose, or since reset.
- R9: S1 and S3 are never on together. At a change of half-cycle, both are off for at least DEAD cycles.
- R10: S1 and S2 are never on together, and S3 and S4 are never on together. If a gate update would break this rule, all gates go low. S5 is on only while one diagonal pair (S1 with S4, or S2 with S3) is also on.
- R11: The reference magnitude of -2^(REF_W-1) is the full value 2^(REF_W-1), with no wrap. A reference of zero never exceeds the carrier, so it gives steady positive freewheeling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces all gates off |
| ref_in | input | REF_W | Signed sine reference sample |
| gate_o | output | 5 | Gate commands, bit 0 = S1 … bit 4 = S5 |
| mode_o | output | 2 | 0/1 positive conduct/freewheel, 2/3 negative conduct/freewheel |

## Verification
A wrong carrier count or a wrong half-cycle register changes both the gate pattern and mode_o. The change shows within one carrier period, so a per-cycle comparison against an independent model catches it during steady references. A dead-time counter that fails to load lets a gate rise in the cycle right after another gate falls. A pattern decode error lets S5 appear without its diagonal pair, or lets a vertical pair conduct together. These errors show at the gate pins in the same cycle and are compared every cycle.

// File: rtl/h5_gate_gen.sv
module h5_gate_gen #(
  parameter int REF_W = 16,
  parameter int PEAK  = 2500,
  parameter int DEAD  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [REF_W-1:0] ref_in,
  output logic [4:0]              gate_o,
  output logic [1:0]              mode_o
);
  localparam int CW = $clog2(PEAK + 1);
  localparam int DW = (DEAD < 1) ? 1 : $clog2(DEAD + 1);
  localparam logic [4:0] POS_ON = 5'b11001;
  localparam logic [4:0] POS_FW = 5'b00001;
  localparam logic [4:0] NEG_ON = 5'b10110;
  localparam logic [4:0] NEG_FW = 5'b00100;

  logic [CW-1:0]    cnt;
  logic             up;
  logic             half_neg;
  logic [DW-1:0]    dt;
  logic [REF_W-1:0] mag;
  logic             ref_neg, cond, fault;
  logic [4:0]       want, turn_off, turn_on, g_next;

  assign ref_neg  = ref_in[REF_W-1];
  assign mag      = ref_neg ? REF_W'(-ref_in) : REF_W'(ref_in);
  assign cond     = (ref_neg == half_neg) &&
                    ({{CW{1'b0}}, mag} > {{REF_W{1'b0}}, cnt});
  assign want     = half_neg ? (cond ? NEG_ON : NEG_FW) : (cond ? POS_ON : POS_FW);
  assign turn_off = gate_o & ~want;
  assign turn_on  = want & ~gate_o;
  assign g_next   = (gate_o & want) |
                    ((dt == '0 && turn_off == '0) ? turn_on : 5'b0);
  assign fault    = (g_next[0] & g_next[1]) | (g_next[2] & g_next[3]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (up) begin
      if (cnt == CW'(PEAK)) begin
        up  <= 1'b0;
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (cnt == '0) begin
        up  <= 1'b1;
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           half_neg <= 1'b0;
    else if (cnt == '0)   half_neg <= ref_neg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_o <= '0;
      mode_o <= '0;
      dt     <= DW'(DEAD);
    end else if (!en) begin
      gate_o <= '0;
      mode_o <= '0;
      dt     <= DW'(DEAD);
    end else begin
      gate_o <= fault ? 5'b0 : g_next;
      mode_o <= fault ? 2'd0 : {half_neg, ~cond};
      if (turn_off != '0) dt <= DW'(DEAD);
      else if (dt != '0)  dt <= dt - 1'b1;
    end
  end
endmodule

module h5_gate_gen_chk #(
  parameter int DEAD = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [4:0] gate_o,
  input logic [1:0] mode_o
);
  logic [4:0] prev_g;
  int         age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_g <= '0;
      age    <= DEAD;
    end else begin
      prev_g <= gate_o;
      if ((prev_g & ~gate_o) != '0) age <= 0;
      else if (age < DEAD)          age <= age + 1;
    end
  end

  // R1
  disabled_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (gate_o == 5'b0 && mode_o == 2'd0));

  // R8
  dead_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_o & ~prev_g) != 5'b0) |-> (age >= DEAD));

  // R9
  upper_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_o[0] && gate_o[2]));

  // R10
  leg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_o[0] && gate_o[1]) && !(gate_o[2] && gate_o[3]));

  // R10
  link_diag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o[4] |-> ((gate_o[0] && gate_o[3]) || (gate_o[1] && gate_o[2])));

  // R3
  pos_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o[4] && gate_o[0]) |-> (mode_o == 2'd0));

  // R5
  neg_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o[4] && gate_o[2]) |-> (mode_o == 2'd2));
endmodule

bind h5_gate_gen h5_gate_gen_chk #(.DEAD(DEAD)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .gate_o(gate_o), .mode_o(mode_o)
);

// File: tb/h5_gate_gen_tb.sv
module h5_gate_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int REF_W = 8;
  localparam int PEAK  = 8;
  localparam int DEAD  = 2;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    en = 1'b0;
  logic signed [REF_W-1:0] ref_in = '0;
  logic [4:0]              gate_o;
  logic [1:0]              mode_o;

  int errors = 0;
  int checks = 0;
  string tag = "R1";
  bit done = 1'b0;

  logic [6:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  h5_gate_gen #(.REF_W(REF_W), .PEAK(PEAK), .DEAD(DEAD)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .ref_in(ref_in),
    .gate_o(gate_o), .mode_o(mode_o)
  );

  int         ph, m_dt;
  bit         m_half;
  logic [4:0] m_g;
  logic [1:0] m_mode;

  always @(posedge clk) begin
    int tri_v, mag;
    bit neg, cond;
    logic [4:0] d, offs, ons, gn;
    if (!rst_n) begin
      ph = 0; m_half = 0; m_g = '0; m_mode = '0; m_dt = DEAD;
    end else begin
      tri_v = (ph <= PEAK) ? ph : 2*PEAK - ph;
      neg   = (ref_in < 0);
      mag   = neg ? -int'(ref_in) : int'(ref_in);
      cond  = (neg == m_half) && (mag > tri_v);
      if (m_half) d = cond ? 5'b10110 : 5'b00100;
      else        d = cond ? 5'b11001 : 5'b00001;
      if (!en) begin
        m_g = '0; m_mode = '0; m_dt = DEAD;
      end else begin
        offs = m_g & ~d;
        ons  = d & ~m_g;
        gn   = (m_g & d) | ((m_dt == 0 && offs == '0) ? ons : 5'b0);
        m_dt = (offs != '0) ? DEAD : ((m_dt > 0) ? m_dt - 1 : 0);
        m_g  = gn;
        m_mode = {m_half, ~cond};
      end
      if (tri_v == 0) m_half = neg;
      ph = (ph == 2*PEAK - 1) ? 0 : ph + 1;
    end
    exp_q.push_back({m_g, m_mode});
    tag_q.push_back(tag);
  end

  always @(negedge clk) begin
    logic [6:0] e;
    string t;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({gate_o, mode_o} !== e) begin
        errors++;
        $display("FAIL %s gate=%b mode=%0d expected gate=%b mode=%0d",
                 t, gate_o, mode_o, e[6:2], e[1:0]);
      end
      checks++;
      if ((gate_o[0] & gate_o[1]) | (gate_o[2] & gate_o[3]) | (gate_o[0] & gate_o[2])) begin
        errors++;
        $display("FAIL R10 R9 gate=%b expected no shorted pair", gate_o);
      end
    end
  end

  task automatic run(input logic signed [REF_W-1:0] r, input bit e, input int n, input string t);
    @(negedge clk);
    ref_in = r; en = e; tag = t;
    repeat (n) @(negedge clk);
  endtask

  task automatic check_now(input logic [4:0] eg, input logic [1:0] em, input string t);
    #1;
    checks++;
    if (gate_o !== eg || mode_o !== em) begin
      errors++;
      $display("FAIL %s gate=%b mode=%0d expected gate=%b mode=%0d", t, gate_o, mode_o, eg, em);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check_now(5'b0, 2'd0, "R1 reset");
    rst_n = 1'b1;
    run(8'sd5,    1'b1, 48, "R2 R3 R4 R8");
    run(-8'sd6,   1'b1, 48, "R5 R6 R7 R9 R8");
    run(8'sd3,    1'b1, 5,  "R7 mid-carrier flip");
    run(8'sd3,    1'b1, 40, "R9 R3 R4");
    run(8'sd127,  1'b1, 40, "R3 R10 full");
    check_now(5'b11001, 2'd0, "R3 steady full");
    run(-8'sd128, 1'b1, 48, "R11 R5 most negative");
    check_now(5'b10110, 2'd2, "R11 steady most negative");
    run(8'sd0,    1'b1, 40, "R11 R4 zero");
    check_now(5'b00001, 2'd1, "R11 zero freewheel");
    run(8'sd4,    1'b0, 10, "R1 disabled");
    check_now(5'b0, 2'd0, "R1 disabled");
    run(-8'sd2,   1'b1, 48, "R8 R10 R6 re-enable");
    run(-8'sd7,   1'b1, 20, "R2 R5 R6");
    run(8'sd7,    1'b1, 40, "R7 R9 R8 return");
    done = 1'b1;
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule